// File: doc/BRIEF.md
# Half-Duplex Transmit Statistics Counters

This block sits beside the transmit path of an Ethernet MAC and keeps two saturating statistics counters. The first is the deferral counter. It advances once for every clock cycle in which the transmitter is held off. A transmitter is held off when the medium is busy because another station is sending, when a half-duplex deferral is in progress, or when a received pause (XOFF) frame is in force. The second is the missing-carrier counter. It advances once for every frame that completes successfully in half-duplex operation without the PHY having raised carrier sense inside a slot-time window. That window opens when the MAC raises its transmit enable toward the PHY.

Software or a wrapping register file reads either counter through a one-cycle read strobe and a one-bit select. The selected value appears on the registered read data one cycle later. The same read clears the counter, so each read returns the events that arrived since the previous read. If an event arrives in the same cycle as a read, that event is carried into the cleared counter and is not lost. Both counters stop at all ones instead of wrapping. Neither counter moves while transmits are disabled.

The slot time is given in bits and converted to clock cycles. The default is 512 bits at 8 bits per clock, which gives 64 cycles.

Top module: `txstat_counters`

## Requirements
- R1: After reset both counters are zero and rd_data is zero; counters are CNT_W bits wide (default 32).
- R2: A cycle with rd_stb high latches the selected counter into rd_data at that clock edge (rd_sel 0 = deferral counter, rd_sel 1 = missing-carrier counter); rd_data then holds until the next read; the read counter becomes zero.
- R3: The deferral counter adds exactly one for every cycle in which medium_busy or xoff_rcvd is high; both high in one cycle still count one.
- R4: While tx_enable is low, neither counter increments, whatever the other inputs do.
- R5: The transmission window begins in the cycle where phy_txen is high after having been low, and covers that cycle and the following SLOT_CYCLES-1 cycles; phy_crs high in any of those cycles marks the frame as having carrier, and phy_crs outside the window has no effect.
- R6: A tx_ok pulse for a pending frame that lacked carrier adds one to the missing-carrier counter; a frame with carrier adds nothing.
- R7: While half_duplex is low, the missing-carrier counter does not increment.
- R8: A frame without a tx_ok pulse is discarded at the next transmission start and never counted; tx_ok with no pending frame counts nothing, and a second tx_ok for the same frame counts nothing.
- R9: When a read and an increment of the same counter fall in one cycle, rd_data returns the value before the increment and the counter restarts at one.
- R10: A counter at all ones stays at all ones on further events until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_enable | input | 1 | Transmit path enabled; gates both counters |
| half_duplex | input | 1 | 1 = half-duplex operation, 0 = full duplex |
| medium_busy | input | 1 | Per-cycle indication that the transmitter is deferring to a busy medium |
| xoff_rcvd | input | 1 | Per-cycle indication that a received pause frame is holding transmission |
| phy_txen | input | 1 | Transmit enable as driven toward the PHY |
| phy_crs | input | 1 | Carrier sense from the PHY |
| tx_ok | input | 1 | One-cycle pulse: the current frame completed successfully |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_sel | input | 1 | Counter select: 0 deferral, 1 missing carrier |
| rd_data | output | CNT_W | Registered read data |

## Verification
Some rules are checked by the in-line properties on every cycle:
- a counter at all ones stays there,
- a counter clears on a read and steps by exactly one otherwise,
- increments are gated by transmit enable and duplex mode,
- the window counter loads and decrements as intended,
- carrier, once seen, stays marked for the frame.

Other behaviour only the bench scenarios can show. The bench sweeps the carrier-sense position across every cycle inside and just beyond the slot window. It walks every combination of the two defer causes with transmit enable on and off. It also checks that aborted frames are dropped, and that a read landing on an increment returns the old count while the counter restarts at one.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

  typedef enum logic {
    SEL_DEFER = 1'b0,
    SEL_NOCRS = 1'b1
  } cnt_sel_e;

  localparam int unsigned NUM_CNT = 2;

endpackage

// File: rtl/txstat_rst_sync.sv
module txstat_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/txstat_sat_cnt.sv
module txstat_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  always_comb begin
    cnt_nxt = cnt_q;
    cnt_en  = 1'b0;
    if (clr) begin
      cnt_en  = 1'b1;
      cnt_nxt = inc ? W'(1) : '0;
    end else if (inc && (cnt_q != ALL_ONES)) begin
      cnt_en  = 1'b1;
      cnt_nxt = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign cnt = cnt_q;

  // R10: saturation holds at all ones
  p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == ALL_ONES) && !clr |=> cnt_q == ALL_ONES);

  // R2 / R9: a clearing read leaves zero, or one when an event coincides
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !inc |=> cnt_q == '0);
  p_clear_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr && inc |=> cnt_q == W'(1));

  // R3: a single event steps the count by exactly one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && inc && (cnt_q != ALL_ONES) |=> cnt_q == $past(cnt_q) + W'(1));

  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !inc |=> $stable(cnt_q));

endmodule

// File: rtl/txstat_crs_win.sv
module txstat_crs_win #(
  parameter int unsigned SLOT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phy_txen,
  input  logic phy_crs,
  input  logic tx_ok,
  output logic nocrs_done
);

  localparam int unsigned LW = $clog2(SLOT_CYCLES + 1);
  localparam logic [LW-1:0] LOAD_VAL = LW'(SLOT_CYCLES - 1);

  logic          txen_q;
  logic          pend_q,  pend_nxt;
  logic          carr_q,  carr_nxt;
  logic [LW-1:0] left_q,  left_nxt;
  logic          start;
  logic          in_win;
  logic          carr_now;

  assign start    = phy_txen & ~txen_q;
  assign in_win   = (left_q != '0);
  assign carr_now = carr_q | (in_win & phy_crs);

  always_comb begin
    pend_nxt = pend_q;
    carr_nxt = carr_now;
    left_nxt = in_win ? (left_q - LW'(1)) : left_q;
    if (start) begin
      pend_nxt = 1'b1;
      carr_nxt = phy_crs;
      left_nxt = LOAD_VAL;
    end else if (tx_ok) begin
      pend_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txen_q <= 1'b0;
      pend_q <= 1'b0;
      carr_q <= 1'b0;
      left_q <= '0;
    end else begin
      txen_q <= phy_txen;
      pend_q <= pend_nxt;
      carr_q <= carr_nxt;
      left_q <= left_nxt;
    end
  end

  assign nocrs_done = tx_ok & pend_q & ~carr_now;

  // R5: window loads at transmission start and counts down by one
  p_win_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phy_txen && !txen_q |=> left_q == LOAD_VAL && pend_q);
  p_win_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q != '0) && !(phy_txen && !txen_q) |=> left_q == $past(left_q) - LW'(1));
  p_carrier_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    carr_q && !(phy_txen && !txen_q) |=> carr_q);

  // R8: nothing completes without a pending frame; tx_ok retires it
  p_need_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |-> !nocrs_done);
  p_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok && !(phy_txen && !txen_q) |=> !pend_q);

endmodule

// File: rtl/txstat_counters.sv
module txstat_counters
  import txstat_pkg::*;
#(
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned SLOT_BITS    = 512,
  parameter int unsigned BITS_PER_CLK = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable,
  input  logic             half_duplex,
  input  logic             medium_busy,
  input  logic             xoff_rcvd,
  input  logic             phy_txen,
  input  logic             phy_crs,
  input  logic             tx_ok,
  input  logic             rd_stb,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rd_data
);

  localparam int unsigned SLOT_CYCLES = (SLOT_BITS + BITS_PER_CLK - 1) / BITS_PER_CLK;

  logic                 rst_sync_n;
  logic                 nocrs_done;
  logic                 defer_evt;
  logic                 nocrs_evt;
  logic [NUM_CNT-1:0]   inc_vec;
  logic [NUM_CNT-1:0]   clr_vec;
  logic [CNT_W-1:0]     cnt_arr [NUM_CNT];
  logic [CNT_W-1:0]     rd_q;
  logic [CNT_W-1:0]     rd_nxt;
  logic                 rd_en;

  txstat_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  txstat_crs_win #(.SLOT_CYCLES(SLOT_CYCLES)) u_win (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .phy_txen   (phy_txen),
    .phy_crs    (phy_crs),
    .tx_ok      (tx_ok),
    .nocrs_done (nocrs_done)
  );

  assign defer_evt = tx_enable & (medium_busy | xoff_rcvd);
  assign nocrs_evt = tx_enable & half_duplex & nocrs_done;

  always_comb begin
    inc_vec = '0;
    inc_vec[int'(SEL_DEFER)] = defer_evt;
    inc_vec[int'(SEL_NOCRS)] = nocrs_evt;
    for (int i = 0; i < int'(NUM_CNT); i++) begin
      clr_vec[i] = rd_stb && (int'(rd_sel) == i);
    end
  end

  for (genvar g = 0; g < int'(NUM_CNT); g++) begin : g_cnt
    txstat_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .inc   (inc_vec[g]),
      .clr   (clr_vec[g]),
      .cnt   (cnt_arr[g])
    );
  end

  always_comb begin
    rd_en  = rd_stb;
    rd_nxt = cnt_arr[rd_sel];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_nxt;
    end
  end

  assign rd_data = rd_q;

  // R4: no counter event while transmits are disabled
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tx_enable |-> inc_vec == '0);

  // R7: full duplex never feeds the missing-carrier counter
  p_full_duplex_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !half_duplex |-> !inc_vec[int'(SEL_NOCRS)]);

  // R2: read data reflects the counter as it stood at the read edge
  p_read_value_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_stb |=> rd_data == $past(cnt_arr[rd_sel]));
  p_read_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_stb |=> $stable(rd_data));

endmodule

// File: tb/sim_txstat_counters.sv
`timescale 1ns/1ps
module sim_txstat_counters;

  localparam int unsigned CW   = 4;
  localparam int unsigned SLOT = 4;  // 32 bits at 8 bits per clock
  localparam int          FLEN = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_enable, half_duplex, medium_busy, xoff_rcvd;
  logic phy_txen, phy_crs, tx_ok, rd_stb, rd_sel;
  logic [CW-1:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  txstat_counters #(.CNT_W(CW), .SLOT_BITS(32), .BITS_PER_CLK(8)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .half_duplex(half_duplex),
    .medium_busy(medium_busy), .xoff_rcvd(xoff_rcvd), .phy_txen(phy_txen),
    .phy_crs(phy_crs), .tx_ok(tx_ok), .rd_stb(rd_stb), .rd_sel(rd_sel),
    .rd_data(rd_data)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic rd_check(input logic sel, input int exp, input string tag);
    @(negedge clk); rd_stb = 1'b1; rd_sel = sel;
    @(negedge clk); rd_stb = 1'b0;
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic defer_cycles(input logic en, input logic busy, input logic xo, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tx_enable = en; medium_busy = busy; xoff_rcvd = xo;
    end
    @(negedge clk); medium_busy = 1'b0; xoff_rcvd = 1'b0; tx_enable = 1'b1;
  endtask

  // crs_off < 0: no carrier at all
  task automatic frame(input int crs_off, input logic ok, input logic hd, input logic en);
    half_duplex = hd; tx_enable = en;
    for (int k = 0; k < FLEN; k++) begin
      @(negedge clk); phy_txen = 1'b1; phy_crs = (k == crs_off);
    end
    @(negedge clk); phy_txen = 1'b0; phy_crs = 1'b0;
    @(negedge clk); tx_ok = ok;
    @(negedge clk); tx_ok = 1'b0;
    @(negedge clk); tx_enable = 1'b1; half_duplex = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d expected below 20000 cycles", cycles);
        finish_run();
      end
    end
  end

  initial begin
    rst_n = 1'b0; tx_enable = 1'b1; half_duplex = 1'b1; medium_busy = 1'b0;
    xoff_rcvd = 1'b0; phy_txen = 1'b0; phy_crs = 1'b0; tx_ok = 1'b0;
    rd_stb = 1'b0; rd_sel = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 rd_data after reset", int'(rd_data), 0);
    rd_check(1'b0, 0, "R1 deferral counter reset");
    rd_check(1'b1, 0, "R1 missing-carrier counter reset");

    // R3 / R4: every cause combination with transmits on and off
    for (int c = 0; c < 8; c++) begin
      logic en, b, x;
      en = c[2]; b = c[1]; x = c[0];
      defer_cycles(en, b, x, 1);
      rd_check(1'b0, (en && (b || x)) ? 1 : 0, en ? "R3 one event per cycle" : "R4 disabled defer");
    end
    defer_cycles(1'b1, 1'b1, 1'b0, 5);
    rd_check(1'b0, 5, "R3 busy held five cycles");
    defer_cycles(1'b1, 1'b1, 1'b1, 3);
    rd_check(1'b0, 3, "R3 both causes three cycles");

    // R10: saturation at 2^CW-1, then R2 clear
    defer_cycles(1'b1, 1'b0, 1'b1, 20);
    rd_check(1'b0, (1 << CW) - 1, "R10 saturated count");
    rd_check(1'b0, 0, "R2 cleared by previous read");

    // R5 / R6: carrier position sweep across and beyond the window
    for (int off = -1; off < 8; off++) begin
      frame(off, 1'b1, 1'b1, 1'b1);
      rd_check(1'b1, (off < 0 || off >= int'(SLOT)) ? 1 : 0, "R5 carrier window sweep");
    end

    // R7: full duplex, R4: transmits disabled
    frame(-1, 1'b1, 1'b0, 1'b1);
    rd_check(1'b1, 0, "R7 full duplex not counted");
    frame(-1, 1'b1, 1'b1, 1'b0);
    rd_check(1'b1, 0, "R4 missing carrier while disabled");

    // R6: several frames accumulate
    frame(-1, 1'b1, 1'b1, 1'b1);
    frame(-1, 1'b1, 1'b1, 1'b1);
    frame(0,  1'b1, 1'b1, 1'b1);
    rd_check(1'b1, 2, "R6 two of three frames lacked carrier");

    // R8: aborted frame discarded, stray success pulses ignored
    frame(-1, 1'b0, 1'b1, 1'b1);
    frame(1,  1'b1, 1'b1, 1'b1);
    rd_check(1'b1, 0, "R8 aborted frame dropped");
    @(negedge clk); tx_ok = 1'b1;
    @(negedge clk); tx_ok = 1'b0;
    rd_check(1'b1, 0, "R8 tx_ok without pending frame");
    frame(-1, 1'b1, 1'b1, 1'b1);
    @(negedge clk); tx_ok = 1'b1;
    @(negedge clk); tx_ok = 1'b0;
    rd_check(1'b1, 1, "R8 second tx_ok ignored");

    // R9: read coinciding with an increment
    defer_cycles(1'b1, 1'b1, 1'b0, 3);
    @(negedge clk); medium_busy = 1'b1; rd_stb = 1'b1; rd_sel = 1'b0;
    @(negedge clk); medium_busy = 1'b0; rd_stb = 1'b0;
    chk("R9 read returns pre-increment value", int'(rd_data), 3);
    rd_check(1'b0, 1, "R9 counter restarted at one");

    // R2: rd_data holds between reads and the other counter is untouched
    defer_cycles(1'b1, 1'b1, 1'b0, 2);
    repeat (3) @(negedge clk);
    chk("R2 rd_data holds without read", int'(rd_data), 1);
    rd_check(1'b1, 0, "R2 select picks missing-carrier counter");
    rd_check(1'b0, 2, "R2 select picks deferral counter");

    finish_run();
  end

endmodule